// File: doc/BRIEF.md
# Boot Configuration Loader

This block fills a local register file from an external serial EEPROM right after reset. A mode strap selects self-configuration. When it does, the block briefly becomes the master of a two-wire bus. It clears the image area of the register file, reads the image from the EEPROM one byte after another, and writes each byte into its register. It then adds up the image bytes modulo 256 and stores the result in a status register.

A correct image sums to a fixed magic byte. One byte of the image serves as a seed that sets the total. If the sum is wrong, or the EEPROM fails to acknowledge, the block repeats the whole download, up to a bounded number of attempts. Three sticky flags report the outcome: finished, image good, and attempts exhausted. The bus pins are open-drain. An output of 1 pulls the line low, and the line level is read back on the matching input. If a slave holds SCL low while the master has released it, the bit timing waits.

Top module: `boot_cfg_loader`

## Requirements
- R1: When the strap is low at the first cycle after reset, the block never drives SCL or SDA, never writes the register file, and all three flags stay 0.
- R2: Every attempt begins with one write of 00h to each address from 00h to 4Ch. These writes come on consecutive cycles in ascending order.
- R3: Each download follows a fixed bus sequence:
  - START, then address byte A0h (device 1010000b, write), then word address 00h.
  - Repeated START, then A1h (read), then 77 data reads.
  - The master ACKs every data byte except the last, which it NACKs, then sends STOP.
  - While a byte transfers, SCL rises every 4*CLK_DIV clock cycles.
- R4: The n-th byte read in an attempt is written to register address n (00h to 4Ch), in the order it was read.
- R5: After each attempt, the low 8 bits of the sum of that attempt's received bytes are written to address FCh. An attempt that received no data writes 00h.
- R6: If that sum equals 2Eh and every address and word byte was ACKed, valid and done rise in the same cycle as the FCh write. After that the bus stays released and no further writes occur.
- R7: A checksum mismatch starts a complete new attempt, clear phase included. No other writes come between the FCh write and the new clear.
- R8: A NACK from the EEPROM on an address or word byte ends the attempt with STOP, and the attempt counts as failed whatever its sum.
- R9: When MAX_TRIES attempts have failed, timeout and done rise, valid stays 0, and bus activity and writes cease.
- R10: done, valid and timeout hold their value until reset. valid and timeout are never 1 together.
- R11: The block never changes its SCL and SDA drive in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_selfcfg | input | 1 | 1 selects self-configuration at start-up |
| scl_in | input | 1 | Level seen on the SCL line |
| sda_in | input | 1 | Level seen on the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | 8 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |
| cfg_done | output | 1 | Loader finished (good image or attempts exhausted) |
| cfg_valid | output | 1 | Image accepted by checksum |
| cfg_timeout | output | 1 | Attempt limit reached without a good image |

## Verification
The assertions check on every cycle the properties that hold over the whole run:
- SCL and SDA drive never change together.
- Writes go only to the image range or to the checksum register.
- The flags are sticky and never contradict each other.
- valid rises only together with a write of 2Eh to FCh.
- The bus is released once the block is done.

Only the bench scenarios can show the rest:
- the exact write stream of each attempt, including the clear, the image order and the computed sum;
- the number of attempts after a bad image or a mute EEPROM;
- the bus byte sequence, with the NACK on the last byte;
- the SCL period;
- the passive behaviour under a low strap.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [6:0] EEPROM_DEV  = 7'b1010000;
    localparam logic [7:0] WORD_FIRST  = 8'h00;
    localparam logic [7:0] SUM_REG     = 8'hFC;
    localparam logic [7:0] SUM_MAGIC   = 8'h2E;

    typedef enum logic [1:0] {
        BC_START,
        BC_STOP,
        BC_WRITE,
        BC_READ
    } bus_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PARK,
        S_CLEAR,
        S_START,
        S_ADDRW,
        S_WORD,
        S_RSTART,
        S_ADDRR,
        S_READ,
        S_STOP,
        S_CHECK,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } rf_wr_t;

    function automatic logic [BYTE_W-1:0] dev_byte(input logic [6:0] dev, input logic rd);
        return {dev, rd};
    endfunction

endpackage

// File: rtl/bcl_tick.sv
module bcl_tick #(
    parameter int unsigned DIV = 312
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CW'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/bcl_bus_engine.sv
module bcl_bus_engine
    import bcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              go,
    input  bus_cmd_e          cmd,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              ack_send,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              busy,
    output logic              fin,
    output logic [BYTE_W-1:0] rbyte,
    output logic              ack_rx,
    output logic              scl_oe,
    output logic              sda_oe
);
    logic [1:0]        q;
    logic [3:0]        bitn;
    bus_cmd_e          cur;
    logic [BYTE_W-1:0] sh;
    logic              ack_hold;
    logic              drv_low;
    logic              step;
    logic              is_bit;
    logic              last_q;

    // quarter 2 has SCL released: a slave holding it low stretches the bit
    assign step   = busy && tick && !((q == 2'd2) && !scl_in);
    assign is_bit = (cur == BC_WRITE) || (cur == BC_READ);
    assign last_q = (q == 2'd3) && (!is_bit || (bitn == 4'd8));
    assign rbyte  = sh;

    always_comb begin
        if (bitn < 4'd8) begin
            drv_low = (cur == BC_WRITE) ? ~sh[BYTE_W-1] : 1'b0;
        end else begin
            drv_low = (cur == BC_READ) ? ack_hold : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            fin      <= 1'b0;
            q        <= '0;
            bitn     <= '0;
            cur      <= BC_START;
            sh       <= '0;
            ack_hold <= 1'b0;
            ack_rx   <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !busy) begin
                busy     <= 1'b1;
                q        <= '0;
                bitn     <= '0;
                cur      <= cmd;
                sh       <= wbyte;
                ack_hold <= ack_send;
            end else if (step) begin
                q <= q + 2'd1;
                case (cur)
                    BC_START: begin
                        case (q)
                            2'd0: begin scl_oe <= 1'b1; sda_oe <= 1'b0; end
                            2'd1: scl_oe <= 1'b0;
                            2'd2: sda_oe <= 1'b1;
                            default: scl_oe <= 1'b1;
                        endcase
                    end
                    BC_STOP: begin
                        case (q)
                            2'd0: begin scl_oe <= 1'b1; sda_oe <= 1'b1; end
                            2'd1: scl_oe <= 1'b0;
                            2'd2: sda_oe <= 1'b0;
                            default: ;
                        endcase
                    end
                    default: begin
                        case (q)
                            2'd0: sda_oe <= drv_low;
                            2'd1: scl_oe <= 1'b0;
                            2'd2: begin
                                if (bitn < 4'd8) sh <= {sh[BYTE_W-2:0], sda_in};
                                else             ack_rx <= sda_in;
                            end
                            default: begin
                                scl_oe <= 1'b1;
                                bitn   <= bitn + 4'd1;
                            end
                        endcase
                    end
                endcase
                if (last_q) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bcl_checksum.sv
module bcl_checksum
    import bcl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MAGIC = SUM_MAGIC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add_en,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] sum,
    output logic              match
);
    always_ff @(posedge clk) begin
        if (rst || clr) sum <= '0;
        else if (add_en) sum <= sum + din;
    end

    assign match = (sum == MAGIC);
endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader
    import bcl_pkg::*;
#(
    parameter int unsigned CLK_DIV   = 312,
    parameter int unsigned MAX_TRIES = 512,
    parameter logic [7:0]  IMG_LAST  = 8'h4C,
    parameter logic [6:0]  DEV_ADDR  = EEPROM_DEV
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_selfcfg,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       rf_we,
    output logic [7:0] rf_addr,
    output logic [7:0] rf_wdata,
    output logic       cfg_done,
    output logic       cfg_valid,
    output logic       cfg_timeout
);
    localparam int unsigned IDX_W = $clog2(int'(IMG_LAST) + 1);
    localparam int unsigned TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(IMG_LAST);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES - 1);

    seq_state_e        st;
    logic [IDX_W-1:0]  idx;
    logic [TRY_W-1:0]  tries;
    logic              nack_seen;
    rf_wr_t            wr_q;
    logic              done_q, valid_q, tmo_q;

    logic              tick;
    logic              eng_go, eng_busy, eng_fin, eng_ack_rx;
    bus_cmd_e          eng_cmd;
    logic [BYTE_W-1:0] eng_byte, eng_rbyte;
    logic              eng_ack;
    logic              bus_st;
    logic [BYTE_W-1:0] sum;
    logic              sum_ok;

    bcl_tick #(.DIV(CLK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    bcl_bus_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .go      (eng_go),
        .cmd     (eng_cmd),
        .wbyte   (eng_byte),
        .ack_send(eng_ack),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .busy    (eng_busy),
        .fin     (eng_fin),
        .rbyte   (eng_rbyte),
        .ack_rx  (eng_ack_rx),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe)
    );

    bcl_checksum #(.MAGIC(SUM_MAGIC)) u_sum (
        .clk   (clk),
        .rst   (rst),
        .clr   (st == S_CLEAR),
        .add_en((st == S_READ) && eng_fin),
        .din   (eng_rbyte),
        .sum   (sum),
        .match (sum_ok)
    );

    always_comb begin
        eng_cmd  = BC_START;
        eng_byte = '0;
        bus_st   = 1'b1;
        case (st)
            S_START, S_RSTART: eng_cmd = BC_START;
            S_ADDRW: begin eng_cmd = BC_WRITE; eng_byte = dev_byte(DEV_ADDR, 1'b0); end
            S_WORD:  begin eng_cmd = BC_WRITE; eng_byte = WORD_FIRST; end
            S_ADDRR: begin eng_cmd = BC_WRITE; eng_byte = dev_byte(DEV_ADDR, 1'b1); end
            S_READ:  eng_cmd = BC_READ;
            S_STOP:  eng_cmd = BC_STOP;
            default: bus_st = 1'b0;
        endcase
    end

    assign eng_go  = bus_st && !eng_busy && !eng_fin;
    assign eng_ack = (idx != IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            idx       <= '0;
            tries     <= '0;
            nack_seen <= 1'b0;
            wr_q      <= '0;
            done_q    <= 1'b0;
            valid_q   <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            wr_q.we <= 1'b0;
            case (st)
                S_IDLE: begin
                    idx       <= '0;
                    nack_seen <= 1'b0;
                    st        <= strap_selfcfg ? S_CLEAR : S_PARK;
                end
                S_CLEAR: begin
                    wr_q <= '{we: 1'b1, addr: 8'(idx), data: '0};
                    if (idx == IDX_LAST) begin
                        idx <= '0;
                        st  <= S_START;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                S_START:  if (eng_fin) st <= S_ADDRW;
                S_RSTART: if (eng_fin) st <= S_ADDRR;
                S_ADDRW, S_WORD, S_ADDRR: begin
                    if (eng_fin) begin
                        if (eng_ack_rx) begin
                            nack_seen <= 1'b1;
                            st        <= S_STOP;
                        end else begin
                            st <= (st == S_ADDRW) ? S_WORD :
                                  (st == S_WORD)  ? S_RSTART : S_READ;
                        end
                    end
                end
                S_READ: begin
                    if (eng_fin) begin
                        wr_q <= '{we: 1'b1, addr: 8'(idx), data: eng_rbyte};
                        if (idx == IDX_LAST) st <= S_STOP;
                        else                 idx <= idx + IDX_W'(1);
                    end
                end
                S_STOP: if (eng_fin) st <= S_CHECK;
                S_CHECK: begin
                    wr_q <= '{we: 1'b1, addr: SUM_REG, data: sum};
                    if (sum_ok && !nack_seen) begin
                        valid_q <= 1'b1;
                        done_q  <= 1'b1;
                        st      <= S_DONE;
                    end else if (tries == TRY_LAST) begin
                        tmo_q  <= 1'b1;
                        done_q <= 1'b1;
                        st     <= S_DONE;
                    end else begin
                        tries     <= tries + TRY_W'(1);
                        idx       <= '0;
                        nack_seen <= 1'b0;
                        st        <= S_CLEAR;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rf_we       = wr_q.we;
    assign rf_addr     = wr_q.addr;
    assign rf_wdata    = wr_q.data;
    assign cfg_done    = done_q;
    assign cfg_valid   = valid_q;
    assign cfg_timeout = tmo_q;
endmodule

// File: rtl/bcl_checker.sv
module bcl_checker (
    input logic       clk,
    input logic       rst,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       rf_we,
    input logic [7:0] rf_addr,
    input logic [7:0] rf_wdata,
    input logic       cfg_done,
    input logic       cfg_valid,
    input logic       cfg_timeout
);
    // R11
    no_dual_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(scl_oe) || $stable(sda_oe));

    // R4
    wr_range_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_addr <= 8'h4C) || (rf_addr == 8'hFC));

    // R6
    valid_with_sum_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid) |-> (rf_we && rf_addr == 8'hFC && rf_wdata == 8'h2E));

    // R6
    bus_idle_when_done_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> (!scl_oe && !sda_oe));

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> cfg_done);

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_valid && cfg_timeout));

    // R9
    timeout_implies_done_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_timeout |-> cfg_done);

    // R10
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> cfg_valid);
endmodule

bind boot_cfg_loader bcl_checker u_bcl_checker (.*);

// File: tb/tb_boot_cfg_loader.sv
module tb_boot_cfg_loader;
    localparam int DIV   = 2;
    localparam int TRIES = 4;
    localparam int LAST  = 8'h4C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap = 1'b0;
    logic scl_oe, sda_oe, rf_we, cfg_done, cfg_valid, cfg_timeout;
    logic [7:0] rf_addr, rf_wdata;
    logic ee_drv = 1'b0;
    logic scl_l, sda_l;

    assign scl_l = ~scl_oe;
    assign sda_l = ~(sda_oe | ee_drv);

    always #4 clk = ~clk;

    boot_cfg_loader #(.CLK_DIV(DIV), .MAX_TRIES(TRIES)) dut (
        .clk(clk), .rst(rst), .strap_selfcfg(strap),
        .scl_in(scl_l), .sda_in(sda_l),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .cfg_done(cfg_done), .cfg_valid(cfg_valid), .cfg_timeout(cfg_timeout)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- EEPROM model ----------------
    logic [7:0] mem [256];
    bit  ee_mute = 1'b0;
    int  ee_mode, ee_cnt, ee_next, n_start, n_stop, n_rd, scl_per, last_rise, n_dual;
    logic [7:0] ee_sh, ee_ptr;
    logic ee_mack, p_scl, p_sda, p_scl_oe, p_sda_oe;

    always @(negedge clk) begin
        if (rst) begin
            ee_mode = 0; ee_cnt = 0; ee_next = 0; ee_drv = 1'b0; ee_ptr = 8'h00;
            n_start = 0; n_stop = 0; n_rd = 0; scl_per = 0; last_rise = 0; n_dual = 0;
            ee_mack = 1'b0; p_scl = 1'b1; p_sda = 1'b1; p_scl_oe = 1'b0; p_sda_oe = 1'b0;
        end else begin
            if ((scl_oe != p_scl_oe) && (sda_oe != p_sda_oe)) n_dual++;
            if (scl_l && p_scl && p_sda && !sda_l) begin
                ee_mode = 1; ee_cnt = 0; ee_drv = 1'b0; n_start++;
            end else if (scl_l && p_scl && !p_sda && sda_l) begin
                ee_mode = 0; ee_drv = 1'b0; n_stop++;
            end else if (scl_l && !p_scl) begin
                if (ee_mode != 0) begin
                    if (ee_cnt >= 1 && ee_cnt <= 7) scl_per = cyc - last_rise;
                    last_rise = cyc;
                    if (ee_cnt < 8) ee_sh = {ee_sh[6:0], sda_l};
                    else if (ee_cnt == 8 && ee_mode == 3) begin ee_mack = sda_l; n_rd++; end
                    ee_cnt++;
                end
            end else if (!scl_l && p_scl && ee_mode != 0) begin
                if (ee_cnt == 8) begin
                    if (ee_mode == 1) begin
                        if (ee_sh[7:1] == 7'b1010000 && !ee_mute) begin
                            ee_drv = 1'b1; ee_next = ee_sh[0] ? 3 : 2;
                        end else begin
                            ee_mode = 0; ee_drv = 1'b0;
                        end
                    end else if (ee_mode == 2) begin
                        ee_ptr = ee_sh; ee_drv = 1'b1;
                    end else begin
                        ee_drv = 1'b0;
                    end
                end else if (ee_cnt == 9) begin
                    ee_cnt = 0;
                    if (ee_mode == 3) begin
                        if (ee_mack) begin ee_mode = 0; ee_drv = 1'b0; end
                        else begin ee_ptr = ee_ptr + 8'd1; ee_drv = ~mem[ee_ptr][7]; end
                    end else if (ee_mode == 1) begin
                        ee_mode = ee_next;
                        ee_drv = (ee_mode == 3) ? ~mem[ee_ptr][7] : 1'b0;
                    end else begin
                        ee_drv = 1'b0;
                    end
                end else if (ee_mode == 3) begin
                    ee_drv = ~mem[ee_ptr][7 - ee_cnt];
                end
            end
            p_scl = scl_l; p_sda = sda_l; p_scl_oe = scl_oe; p_sda_oe = sda_oe;
        end
    end

    // ---------------- scoreboard ----------------
    logic [7:0] q_addr[$];
    logic [7:0] q_data[$];
    string      q_req[$];
    int mon_vec = 0, mon_miss = 0, fc_cnt = 0;
    int n_vec = 0, n_miss = 0;

    always @(negedge clk) begin
        if (!rst && rf_we) begin
            mon_vec++;
            if (rf_addr == 8'hFC) fc_cnt++;
            if (q_addr.size() == 0) begin
                mon_miss++;
                $display("FAIL R7 unexpected write: got addr %0h data %0h expected none",
                         rf_addr, rf_wdata);
            end else begin
                automatic logic [7:0] ea = q_addr.pop_front();
                automatic logic [7:0] ed = q_data.pop_front();
                automatic string      er = q_req.pop_front();
                if (rf_addr !== ea || rf_wdata !== ed) begin
                    mon_miss++;
                    $display("FAIL %s write: got %0h/%0h expected %0h/%0h",
                             er, rf_addr, rf_wdata, ea, ed);
                end
            end
        end
    end

    task automatic push_wr(input logic [7:0] a, input logic [7:0] d, input string r);
        q_addr.push_back(a); q_data.push_back(d); q_req.push_back(r);
    endtask

    task automatic push_attempt(input bit acked);
        automatic int s = 0;
        for (int i = 0; i <= LAST; i++) push_wr(8'(i), 8'h00, "R2");
        if (acked) begin
            for (int i = 0; i <= LAST; i++) begin
                push_wr(8'(i), mem[i], "R4");
                s += int'(mem[i]);
            end
            push_wr(8'hFC, 8'(s), "R5");
        end else begin
            push_wr(8'hFC, 8'h00, "R8");
        end
    endtask

    task automatic load_image(input bit good);
        automatic int s = 0;
        for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
        for (int i = 0; i <= LAST; i++) begin
            mem[i] = 8'((i * 37 + 11) & 255);
            if (i != 1) s += int'(mem[i]);
        end
        mem[1] = 8'(8'h2E - s);
        if (!good) mem[1] = mem[1] + 8'd1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit s);
        rst = 1'b1;
        strap = s;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_done();
        while (!cfg_done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==",
                 n_vec + mon_vec + 1, n_miss + mon_miss + 1);
        $finish;
    end

    initial begin : driver
        int fc0;
        load_image(1'b1);

        // R1: strap low, passive
        do_reset(1'b0);
        check(cfg_done == 0 && cfg_valid == 0 && cfg_timeout == 0, "R1 flags after reset",
              {cfg_done, cfg_valid, cfg_timeout}, 0);
        check(scl_oe == 0 && sda_oe == 0, "R1 bus released after reset", {scl_oe, sda_oe}, 0);
        repeat (400) @(negedge clk);
        check(n_start == 0 && scl_oe == 0 && sda_oe == 0, "R1 no bus activity", n_start, 0);
        check(cfg_done == 0, "R1 done stays low", cfg_done, 0);

        // good image, single attempt
        load_image(1'b1);
        push_attempt(1'b1);
        do_reset(1'b1);
        wait_done();
        check(cfg_valid == 1, "R6 valid", cfg_valid, 1);
        check(cfg_timeout == 0, "R10 timeout low with valid", cfg_timeout, 0);
        check(q_addr.size() == 0, "R4 all image writes seen", q_addr.size(), 0);
        check(n_start == 2, "R3 start count", n_start, 2);
        check(n_stop == 1, "R3 stop count", n_stop, 1);
        check(n_rd == LAST + 1, "R3 bytes read", n_rd, LAST + 1);
        check(ee_mack == 1'b1, "R3 last byte NACKed", ee_mack, 1);
        check(scl_per == 4 * DIV, "R3 SCL period", scl_per, 4 * DIV);
        repeat (300) @(negedge clk);
        check(n_start == 2 && cfg_done == 1 && cfg_valid == 1, "R10 flags held, bus quiet",
              n_start, 2);
        check(n_dual == 0, "R11 no simultaneous SCL/SDA change", n_dual, 0);

        // bad image, exhaust attempts
        load_image(1'b0);
        for (int a = 0; a < TRIES; a++) push_attempt(1'b1);
        do_reset(1'b1);
        wait_done();
        check(cfg_timeout == 1, "R9 timeout", cfg_timeout, 1);
        check(cfg_valid == 0, "R9 valid low", cfg_valid, 0);
        check(q_addr.size() == 0, "R7 all attempts repeated", q_addr.size(), 0);
        check(n_start == 2 * TRIES, "R7 starts per attempts", n_start, 2 * TRIES);
        repeat (300) @(negedge clk);
        check(n_start == 2 * TRIES && cfg_done == 1, "R9 idle after timeout", n_start, 2 * TRIES);

        // mute EEPROM on first attempt, then good
        load_image(1'b1);
        ee_mute = 1'b1;
        push_attempt(1'b0);
        push_attempt(1'b1);
        fc0 = fc_cnt;
        do_reset(1'b1);
        while (fc_cnt == fc0) @(negedge clk);
        ee_mute = 1'b0;
        wait_done();
        check(cfg_valid == 1 && cfg_timeout == 0, "R8 recovered after NACK", cfg_valid, 1);
        check(q_addr.size() == 0, "R8 failed attempt then full retry", q_addr.size(), 0);
        check(n_start == 3, "R8 start count", n_start, 3);
        check(n_dual == 0, "R11 no simultaneous SCL/SDA change", n_dual, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec + mon_vec, n_miss + mon_miss);
        $finish;
    end
endmodule